// File: doc/BRIEF.md
# Banked Maskable Interrupt Collector

This block gathers 24 external interrupt request lines into one cascade request for a host interrupt controller. The sources are grouped into three byte-wide banks (sources 0-7, 8-15 and 16-23). Each bank has a status byte and a mask byte that the host reaches through a small synchronous register port. Every request line first passes through a two-flop synchronizer. All sources but one are edge-latched. A rising edge is captured only while the source is enabled, and reading the status byte acknowledges it. One designated source (index 5 by default) is level-following: its status bit shows the synchronized line itself.

The cascade output is high whenever any status bit is set together with its mask bit. A read that empties the pending set drops the cascade line. A later request raises it again, so a host that detects rising edges sees one edge for each new group of requests. The host changes single mask bits by reading the whole mask byte, editing it and writing it back, so each mask byte reads back exactly as written.

The register port has no back-pressure. A read or write strobe is accepted in the cycle it is high. Read data is registered and appears in the cycle after the read strobe, then holds until the next read.

Top module: `irqagg_top`

## Requirements
- R1: After reset all mask bytes read 0, all latched status bits are 0, `irq_out` is 0 and `host_rdata` is 0.
- R2: Register offsets are 0 status low, 1 mask low, 2 status high, 3 mask high, 4 status extension, 5 mask extension. Offsets 6 and 7 read 0. Read data appears on `host_rdata` after the clock edge that samples `host_rd`.
- R3: An enabled edge source i (bank i/8, bit i%8) sets its status bit on the third rising clock edge after its input rises. The two synchronizer stages account for two of those edges.
- R4: A rising edge on a source whose mask bit is 0 is dropped. If the input stays high and the source is then unmasked, no status bit and no cascade request appear.
- R5: Reading a status byte returns its value before the read, then clears that byte's latched edge bits. Other banks are unaffected.
- R6: When a new edge is captured on the same clock edge as a read of its status byte, the bit stays set.
- R7: The level source's status bit (bit 5 of the low bank by default) equals its synchronized input. A status read does not clear it.
- R8: `irq_out` is high exactly when some bank has a bit set in both status and mask. It drops once reads clear the pending bits.
- R9: Writes to status offsets (0, 2, 4) change no state.
- R10: Each mask byte reads back the last byte written to it. A mask bit of 1 enables its source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 24 | Asynchronous request lines, one per source |
| host_rd | input | 1 | Read strobe for the addressed register |
| host_wr | input | 1 | Write strobe for the addressed register |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| irq_out | output | 1 | Cascade request, OR of all enabled pending bits |

## Verification
The hardest case to reach from the ports is a status read that lands on the same clock edge as a new edge being latched in that byte. Hitting it needs the three-stage input path to be counted exactly. The stimulus raises a source, waits two clock edges for the synchronizer and issues the read in the third cycle. It then checks two things: the returned byte lacks the new bit, and a second read shows the new bit survived while an older bit was cleared. The masked-edge drop is reached by raising a line while it is disabled, then enabling it with the line still high.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int BANK_W = 8;
  typedef logic [BANK_W-1:0] byte_t;
endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/irqagg_bank.sv
module irqagg_bank import irqagg_pkg::*; #(
  parameter byte_t LVL_MASK = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  byte_t req_s,
  input  logic  mask_we,
  input  byte_t wdata,
  input  logic  stat_rd,
  output byte_t stat,
  output byte_t mask_q,
  output logic  pend
);
  byte_t prev_q;
  byte_t edge_q;
  byte_t rise;
  byte_t set_vec;

  assign rise    = req_s & ~prev_q;
  assign set_vec = rise & mask_q & ~LVL_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      mask_q <= '0;
      edge_q <= '0;
    end else begin
      prev_q <= req_s;
      if (mask_we) mask_q <= wdata;
      edge_q <= ((stat_rd ? '0 : edge_q) | set_vec) & ~LVL_MASK;
    end
  end

  assign stat = (edge_q & ~LVL_MASK) | (req_s & LVL_MASK);
  assign pend = |(stat & mask_q);

  // R4: a latched bit may only appear where the mask was enabled
  p_masked_edge_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_q & ~$past(edge_q) & ~$past(mask_q)) == '0));

  // R5: a status read leaves only freshly captured bits
  p_clear_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> ((edge_q & ~$past(set_vec)) == '0));

  // R6: capture on the read edge survives
  p_set_beats_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> ((edge_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top import irqagg_pkg::*; #(
  parameter  int N_BANKS   = 3,
  parameter  int LEVEL_SRC = 5,
  localparam int N_SRC     = N_BANKS * BANK_W,
  localparam int ADDR_W    = $clog2(2 * N_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_req,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [BANK_W-1:0] host_wdata,
  output logic [BANK_W-1:0] host_rdata,
  output logic              irq_out
);
  logic [N_SRC-1:0]   req_s;
  byte_t              stat_v [N_BANKS];
  byte_t              mask_v [N_BANKS];
  logic [N_BANKS-1:0] pend_v;
  logic [N_BANKS-1:0] any_mask;
  byte_t              rd_mux;
  byte_t              rdata_q;

  irqagg_sync #(.W(N_SRC)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (irq_req),
    .sync_out (req_s)
  );

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    localparam byte_t LM = ((LEVEL_SRC / BANK_W) == b)
                           ? byte_t'(1) << (LEVEL_SRC % BANK_W) : '0;
    logic stat_rd;
    logic mask_we;

    assign stat_rd = host_rd && (int'(host_addr) == 2 * b);
    assign mask_we = host_wr && (int'(host_addr) == 2 * b + 1);

    irqagg_bank #(.LVL_MASK(LM)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_s   (req_s[b*BANK_W +: BANK_W]),
      .mask_we (mask_we),
      .wdata   (host_wdata),
      .stat_rd (stat_rd),
      .stat    (stat_v[b]),
      .mask_q  (mask_v[b]),
      .pend    (pend_v[b])
    );

    assign any_mask[b] = |mask_v[b];

    // R10: mask byte reads back what it holds
    p_mask_readback_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && (int'(host_addr) == 2 * b + 1)) |=> (host_rdata == $past(mask_v[b])));
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < N_BANKS; b++) begin
      if (int'(host_addr) == 2 * b)     rd_mux = stat_v[b];
      if (int'(host_addr) == 2 * b + 1) rd_mux = mask_v[b];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rdata_q <= '0;
    else if (host_rd) rdata_q <= rd_mux;
  end

  assign host_rdata = rdata_q;
  assign irq_out    = |pend_v;

  // R8: cascade needs at least one enabled source
  p_cascade_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (|any_mask));

  // R2: offsets past the register set read zero
  p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && (int'(host_addr) >= 2 * N_BANKS)) |=> (host_rdata == '0));
endmodule

// File: tb/test_irqagg_top.sv
`timescale 1ns/1ps
module test_irqagg_top;
  typedef struct packed {
    logic [23:0] req;
    logic        wr;
    logic        rd;
    logic [2:0]  addr;
    logic [7:0]  wdata;
    logic [7:0]  erd;
    logic        eirq;
    logic [3:0]  rid;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{24'h000000, 1'b1, 1'b0, 3'd1, 8'hFF, 8'h00, 1'b0, 4'd10}, // R10 enable low bank
    '{24'h000000, 1'b0, 1'b1, 3'd1, 8'h00, 8'hFF, 1'b0, 4'd10}, // R10 readback
    '{24'h000001, 1'b0, 1'b1, 3'd0, 8'h00, 8'h01, 1'b0, 4'd3},  // R3 capture bit0
    '{24'h000001, 1'b0, 1'b1, 3'd0, 8'h00, 8'h00, 1'b0, 4'd5},  // R5 cleared
    '{24'h000000, 1'b1, 1'b0, 3'd3, 8'h00, 8'h00, 1'b0, 4'd10}, // high bank disabled
    '{24'h000100, 1'b0, 1'b1, 3'd2, 8'h00, 8'h00, 1'b0, 4'd4},  // R4 masked edge
    '{24'h000100, 1'b1, 1'b0, 3'd3, 8'h01, 8'h00, 1'b0, 4'd4},  // R4 unmask, no irq
    '{24'h000100, 1'b0, 1'b1, 3'd2, 8'h00, 8'h00, 1'b0, 4'd4},  // R4 still empty
    '{24'h000000, 1'b0, 1'b0, 3'd0, 8'h00, 8'h00, 1'b0, 4'd3},  // idle, line falls
    '{24'h000100, 1'b1, 1'b0, 3'd5, 8'h80, 8'h00, 1'b1, 4'd8},  // R8 irq rises
    '{24'h800100, 1'b0, 1'b1, 3'd2, 8'h00, 8'h01, 1'b1, 4'd5},  // R5 other bank kept
    '{24'h800100, 1'b0, 1'b1, 3'd4, 8'h00, 8'h80, 1'b0, 4'd8},  // R8 irq drops
    '{24'h800120, 1'b0, 1'b1, 3'd0, 8'h00, 8'h20, 1'b1, 4'd7},  // R7 level high
    '{24'h800120, 1'b0, 1'b1, 3'd0, 8'h00, 8'h20, 1'b1, 4'd7},  // R7 not cleared
    '{24'h800100, 1'b0, 1'b1, 3'd0, 8'h00, 8'h00, 1'b0, 4'd7},  // R7 level low
    '{24'h800100, 1'b1, 1'b0, 3'd0, 8'hFF, 8'h00, 1'b0, 4'd9},  // R9 status write
    '{24'h800100, 1'b0, 1'b1, 3'd0, 8'h00, 8'h00, 1'b0, 4'd9},  // R9 no effect
    '{24'h800100, 1'b0, 1'b1, 3'd6, 8'h00, 8'h00, 1'b0, 4'd2},  // R2 unused offset
    '{24'h800100, 1'b1, 1'b0, 3'd1, 8'h5A, 8'h00, 1'b0, 4'd10},
    '{24'h800100, 1'b0, 1'b1, 3'd1, 8'h00, 8'h5A, 1'b0, 4'd10},
    '{24'h800100, 1'b0, 1'b1, 3'd5, 8'h00, 8'h80, 1'b0, 4'd10},
    '{24'h800100, 1'b0, 1'b1, 3'd3, 8'h00, 8'h01, 1'b0, 4'd10}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] irq_req = '0;
  logic        host_rd = 1'b0;
  logic        host_wr = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        irq_out;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  irqagg_top i_irqagg_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_req    (irq_req),
    .host_rd    (host_rd),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .irq_out    (irq_out)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op(input logic wr, input logic rd, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = wr; host_rd = rd; host_addr = a; host_wdata = d;
    @(posedge clk);
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 rdata", host_rdata, 8'h00);
    check("R1 irq", {7'd0, irq_out}, 8'h00);
    for (int b = 0; b < 3; b++) begin
      op(1'b0, 1'b1, 3'(2 * b + 1), 8'h00);
      check("R1 mask", host_rdata, 8'h00);
      op(1'b0, 1'b1, 3'(2 * b), 8'h00);
      check("R1 status", host_rdata, 8'h00);
    end

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      irq_req = VECS[v].req;
      repeat (4) @(posedge clk);
      op(VECS[v].wr, VECS[v].rd, VECS[v].addr, VECS[v].wdata);
      if (VECS[v].rd)
        check($sformatf("R%0d vec %0d rdata", VECS[v].rid, v), host_rdata, VECS[v].erd);
      check($sformatf("R%0d vec %0d irq", VECS[v].rid, v), {7'd0, irq_out}, {7'd0, VECS[v].eirq});
    end

    // R3 latency: mask low is 0x5A, bit1 enabled
    @(negedge clk);
    irq_req = 24'h800102;
    @(posedge clk); @(negedge clk);
    check("R3 after 1 edge", {7'd0, irq_out}, 8'h00);
    @(posedge clk); @(negedge clk);
    check("R3 after 2 edges", {7'd0, irq_out}, 8'h00);
    @(posedge clk); @(negedge clk);
    check("R3 after 3 edges", {7'd0, irq_out}, 8'h01);
    op(1'b0, 1'b1, 3'd0, 8'h00);
    check("R3 status bit1", host_rdata, 8'h02);

    // R6 read on the capture edge
    @(negedge clk);
    irq_req = 24'h80010A;
    repeat (4) @(posedge clk);
    @(negedge clk);
    irq_req = 24'h80011A;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    host_rd = 1'b1; host_addr = 3'd0;
    @(posedge clk); @(negedge clk);
    host_rd = 1'b0;
    check("R5 pre-clear value", host_rdata, 8'h08);
    check("R6 irq kept", {7'd0, irq_out}, 8'h01);
    op(1'b0, 1'b1, 3'd0, 8'h00);
    check("R6 new bit survived", host_rdata, 8'h10);
    check("R8 irq dropped", {7'd0, irq_out}, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule